// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns a bank of interrupt input lines into a request vector for a downstream priority resolver. For each line, a trigger-mode bit selects between edge and level behaviour. In edge mode a request is latched on a rising transition. It stays latched until the line goes low or the line is acknowledged. In level mode the request follows the line and is not removed by an acknowledge.

Software writes the trigger-mode register through a small write/read port. A constant per-instance mask limits which lines may be switched to level mode. A re-initialise strobe clears every latched request and the recorded line history but leaves the trigger-mode register alone. A pulse request on one line forces a rising transition on that line, even if the physical input is already high.

Top module: `irq_request_latch`

## Requirements
- R1: While `rst_n` is low at a clock edge, `req_out` and `mode_rdata` become all zero.
- R2: A mode write stores `mode_wdata & MODE_MASK`, which `mode_rdata` shows from the next cycle on. A line whose mask bit is 0 reads back 0 and stays edge-triggered. Default `MODE_MASK` is 8'hF8.
- R3: A line with mode bit 1 (level) gives `req_out` bit equal to its input in the previous cycle.
- R4: A line with mode bit 0 (edge) sets its request one cycle after its input is high following a low (or freshly cleared) recorded level.
- R5: A low input clears that line's request and recorded level in both modes.
- R6: An acknowledge (`ack_vld`, `ack_idx` = line number) clears an edge-mode request. A rising transition detected in the same cycle wins, and the request stays set.
- R7: An acknowledge of a level-mode line has no effect on its request.
- R8: `init_clr` clears all requests and recorded levels and preserves the trigger-mode register. An edge line still held high therefore requests again one cycle after the clear.
- R9: A pulse (`pulse_vld`, `pulse_idx` = line number) sets that line's request in the next cycle, whatever the recorded level.
- R10: An edge line held high after being acknowledged does not request again until it goes low and high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears all state |
| init_clr | input | 1 | Re-initialise: clear requests and history, keep modes |
| line_in | input | LINES | Synchronised interrupt input lines |
| pulse_vld | input | 1 | Force a rising transition on one line |
| pulse_idx | input | IDXW | Line index for the pulse |
| mode_wr | input | 1 | Trigger-mode register write strobe |
| mode_wdata | input | LINES | Trigger-mode write data, 1 = level |
| mode_rdata | output | LINES | Trigger-mode register contents |
| ack_vld | input | 1 | Interrupt acknowledge strobe |
| ack_idx | input | IDXW | Line index being acknowledged |
| req_out | output | LINES | Request register to the priority resolver |

## Verification
The hardest case to reach is an acknowledge that lands in the same cycle as a fresh rising transition on the same line. An acknowledge-first rule loses the request without any visible error. The stimulus holds the line low, then raises it and acknowledges it in one cycle. A second hard case is a line held high across `init_clr`. Here the stimulus latches and acknowledges the request, keeps the line high, then re-initialises, and expects the request to return on its own one cycle later.

// File: rtl/irq_lat_pkg.sv
// Shared types for the interrupt request latch.
package irq_lat_pkg;

    // Per-line trigger selection as stored in the mode register.
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

endpackage

// File: rtl/irq_mode_reg.sv
// Trigger-mode register.
// Holds one mode bit per line. Writes are filtered by a constant mask so that
// lines not allowed to be level-sensitive always hold 0 (edge).
// Assumes a synchronous active-low reset; init is handled elsewhere and does
// not touch this register.
module irq_mode_reg #(
    parameter int          LINES     = 8,
    parameter logic [LINES-1:0] MODE_MASK = 8'hF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LINES-1:0] wr_data,
    output logic [LINES-1:0] mode_q
);

    // Store masked write data; reset to all-edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_en)
            mode_q <= wr_data & MODE_MASK;
    end

endmodule

// File: rtl/irq_index_decode.sv
// Decodes a valid strobe plus a line index into a one-hot line vector.
// Indices at or beyond LINES produce no hit.
module irq_index_decode #(
    parameter int LINES = 8,
    localparam int IDXW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             vld,
    input  logic [IDXW-1:0]  idx,
    output logic [LINES-1:0] hit
);

    // One comparator per line.
    for (genvar g = 0; g < LINES; g++) begin : g_dec
        assign hit[g] = vld && (idx == IDXW'(g));
    end

endmodule

// File: rtl/irq_line_cell.sv
// Request state for one interrupt line.
// Keeps the latched request and the recorded previous level. A pulse acts as
// a high input with a cleared history for that cycle. In edge mode a detected
// rising transition takes precedence over an acknowledge in the same cycle.
// Assumes line_in is already synchronised to clk.
module irq_line_cell
    import irq_lat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_clr,
    input  logic       line_in,
    input  trig_mode_e mode,
    input  logic       ack_hit,
    input  logic       pulse_hit,
    output logic       req_q
);

    logic prev_q;
    logic eff_high;
    logic rise_seen;
    logic req_d;

    // Effective level and rising-transition detect.
    assign eff_high  = line_in | pulse_hit;
    assign rise_seen = eff_high & (~prev_q | pulse_hit);

    // Next request value by trigger mode.
    always_comb begin
        req_d = req_q;
        if (mode == TRIG_LEVEL)
            req_d = eff_high;
        else if (!eff_high)
            req_d = 1'b0;
        else if (rise_seen)
            req_d = 1'b1;
        else if (ack_hit)
            req_d = 1'b0;
    end

    // Request and history registers; init clears both like reset.
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr) begin
            req_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            req_q  <= req_d;
            prev_q <= eff_high;
        end
    end

endmodule

// File: rtl/irq_request_latch.sv
// Interrupt request latch, top level.
// Captures LINES interrupt inputs into a request vector with per-line edge or
// level triggering, masked mode writes, acknowledge and pulse strobes.
// Assumes synchronised inputs and a single clock; reset is synchronous and
// active low.
module irq_request_latch
    import irq_lat_pkg::*;
#(
    parameter int               LINES     = 8,
    parameter logic [LINES-1:0] MODE_MASK = 8'hF8,
    localparam int              IDXW      = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_clr,
    input  logic [LINES-1:0] line_in,
    input  logic             pulse_vld,
    input  logic [IDXW-1:0]  pulse_idx,
    input  logic             mode_wr,
    input  logic [LINES-1:0] mode_wdata,
    output logic [LINES-1:0] mode_rdata,
    input  logic             ack_vld,
    input  logic [IDXW-1:0]  ack_idx,
    output logic [LINES-1:0] req_out
);

    logic [LINES-1:0] mode_q;
    logic [LINES-1:0] ack_hit;
    logic [LINES-1:0] pulse_hit;

    irq_mode_reg #(.LINES(LINES), .MODE_MASK(MODE_MASK)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .wr_data (mode_wdata),
        .mode_q  (mode_q)
    );

    irq_index_decode #(.LINES(LINES)) u_ack_dec (
        .vld (ack_vld),
        .idx (ack_idx),
        .hit (ack_hit)
    );

    irq_index_decode #(.LINES(LINES)) u_pulse_dec (
        .vld (pulse_vld),
        .idx (pulse_idx),
        .hit (pulse_hit)
    );

    // One request cell per line.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        irq_line_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .init_clr  (init_clr),
            .line_in   (line_in[g]),
            .mode      (trig_mode_e'(mode_q[g])),
            .ack_hit   (ack_hit[g]),
            .pulse_hit (pulse_hit[g]),
            .req_q     (req_out[g])
        );
    end

    assign mode_rdata = mode_q;

endmodule

// File: rtl/irq_request_latch_chk.sv
// Property checker for irq_request_latch, bound to every instance.
module irq_request_latch_chk #(
    parameter int               LINES     = 8,
    parameter logic [LINES-1:0] MODE_MASK = 8'hF8,
    localparam int              IDXW      = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_clr,
    input logic [LINES-1:0] line_in,
    input logic             pulse_vld,
    input logic [IDXW-1:0]  pulse_idx,
    input logic             mode_wr,
    input logic [LINES-1:0] mode_wdata,
    input logic [LINES-1:0] mode_rdata,
    input logic             ack_vld,
    input logic [IDXW-1:0]  ack_idx,
    input logic [LINES-1:0] req_out
);

    assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> mode_rdata == ($past(mode_wdata) & MODE_MASK));

    assert_init_keeps_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_clr && !mode_wr) |=> (req_out == '0) && (mode_rdata == $past(mode_rdata)));

    assert_pulse_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_vld && !init_clr && (int'(pulse_idx) < LINES))
            |=> req_out[$past(pulse_idx)]);

    for (genvar g = 0; g < LINES; g++) begin : g_prop
        logic p_hit;
        logic a_hit;
        assign p_hit = pulse_vld && (pulse_idx == IDXW'(g));
        assign a_hit = ack_vld && (ack_idx == IDXW'(g));

        assert_level_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_rdata[g] && !init_clr && !p_hit) |=> req_out[g] == $past(line_in[g]));

        assert_low_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!line_in[g] && !p_hit) |=> !req_out[g]);

        assert_edge_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_rdata[g] && a_hit && !p_hit && !init_clr && line_in[g]
                && $past(line_in[g]) && $past(rst_n) && !$past(init_clr))
            |=> !req_out[g]);

        assert_level_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_rdata[g] && a_hit && line_in[g] && !init_clr) |=> req_out[g]);
    end

endmodule

bind irq_request_latch irq_request_latch_chk #(
    .LINES     (LINES),
    .MODE_MASK (MODE_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_clr   (init_clr),
    .line_in    (line_in),
    .pulse_vld  (pulse_vld),
    .pulse_idx  (pulse_idx),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .mode_rdata (mode_rdata),
    .ack_vld    (ack_vld),
    .ack_idx    (ack_idx),
    .req_out    (req_out)
);

// File: tb/irq_request_latch_bench.sv
module irq_request_latch_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_clr = 1'b0;
    logic [7:0] line_in = '0;
    logic       pulse_vld = 1'b0;
    logic [2:0] pulse_idx = '0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] mode_rdata;
    logic       ack_vld = 1'b0;
    logic [2:0] ack_idx = '0;
    logic [7:0] req_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_request_latch u_irq_request_latch (
        .clk(clk), .rst_n(rst_n), .init_clr(init_clr), .line_in(line_in),
        .pulse_vld(pulse_vld), .pulse_idx(pulse_idx), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .mode_rdata(mode_rdata), .ack_vld(ack_vld),
        .ack_idx(ack_idx), .req_out(req_out)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One clock edge, then settle at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        pulse_vld = 1'b0; ack_vld = 1'b0; mode_wr = 1'b0; init_clr = 1'b0;
    endtask

    task automatic write_mode(logic [7:0] v);
        mode_wr = 1'b1; mode_wdata = v;
        step();
    endtask

    task automatic ack(int n);
        ack_vld = 1'b1; ack_idx = 3'(n);
    endtask

    task automatic t_reset();
        line_in = 8'hFF;
        write_mode(8'hF8);
        rst_n = 1'b0;
        step();
        chk("R1 req after reset", req_out, 8'h00);
        chk("R1 mode after reset", mode_rdata, 8'h00);
        rst_n = 1'b1; line_in = '0;
        step();
    endtask

    task automatic t_mode_write();
        write_mode(8'hFF);
        chk("R2 masked write FF", mode_rdata, 8'hF8);
        write_mode(8'h0F);
        chk("R2 masked write 0F", mode_rdata, 8'h08);
        // Line 0 is masked: stays edge, so ack clears it while held high.
        write_mode(8'h01);
        chk("R2 line0 not level", mode_rdata, 8'h00);
        line_in = 8'h01; step();
        ack(0); step();
        chk("R2 masked line acts as edge", req_out, 8'h00);
        line_in = '0; step();
    endtask

    task automatic t_level();
        write_mode(8'h08);
        line_in = 8'h08; step();
        chk("R3 level high", req_out, 8'h08);
        ack(3); step();
        chk("R7 level ack ignored", req_out, 8'h08);
        line_in = '0; step();
        chk("R3 level low", req_out, 8'h00);
        line_in = 8'h08; step(); step();
        chk("R3 level high again", req_out, 8'h08);
        line_in = '0; step();
    endtask

    task automatic t_edge();
        write_mode(8'h00);
        line_in = 8'h01; step();
        chk("R4 edge latched", req_out, 8'h01);
        step();
        chk("R4 edge held", req_out, 8'h01);
        ack(0); step();
        chk("R6 edge ack clears", req_out, 8'h00);
        step(); step();
        chk("R10 held high no rerequest", req_out, 8'h00);
        line_in = '0; step();
        line_in = 8'h01; step();
        chk("R4 new edge", req_out, 8'h01);
        line_in = '0; step();
        chk("R5 edge low clears", req_out, 8'h00);
    endtask

    task automatic t_ack_race();
        line_in = 8'h02; ack(1); step();
        chk("R6 edge wins over ack", req_out, 8'h02);
        line_in = '0; step();
    endtask

    task automatic t_init();
        write_mode(8'h80);
        line_in = 8'h10; step();
        ack(4); step();
        chk("R8 setup acked", req_out, 8'h00);
        init_clr = 1'b1; step();
        chk("R8 init clears req", req_out, 8'h00);
        chk("R8 init keeps mode", mode_rdata, 8'h80);
        step();
        chk("R8 held line requests after init", req_out, 8'h10);
        line_in = '0; step();
    endtask

    task automatic t_pulse();
        write_mode(8'h00);
        line_in = 8'h20; step();
        ack(5); step();
        pulse_vld = 1'b1; pulse_idx = 3'd5; step();
        chk("R9 pulse on high line", req_out, 8'h20);
        line_in = '0; step();
        pulse_vld = 1'b1; pulse_idx = 3'd6; step();
        chk("R9 pulse on low line", req_out, 8'h40);
        step();
        chk("R5 low after pulse clears", req_out, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_mode_write();
        t_level();
        t_edge();
        t_ack_race();
        t_init();
        t_pulse();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule